// File: doc/BRIEF.md
# Bank Idle Detector for Router Request Prioritization

This block sits beside a router and watches the memory requests that the router forwards. For each memory bank it keeps a small count of the requests seen toward that bank during a recent time window. A separate query port asks whether a given bank has been quiet. When the bank has seen no request in the window, the block raises an expedite flag, and the router's arbiters can use that flag to favour the request. Only traffic seen by this router is used, so no state is shared between routers.

The sliding window is approximated with two sets of per-bank counters that take turns. Each set covers one half of the programmed window length. Records always go into the active set. When a half ends, the sets swap roles and the set that becomes active is cleared. A bank counts as idle when both of its counters are zero. The counters saturate instead of wrapping. The window length is an input, so 100, 200, 400 or any other length fits the counter width.

Top module: `bank_idle_tracker`

## Requirements
- R1: After reset every bank is idle, so a query of any bank in the first cycle after reset returns expedite = 1. A reset in the middle of operation clears all history.
- R2: `qry_expedite_o` is 0 whenever `qry_vld_i` is 0.
- R3: A record of bank b (`rec_vld_i` = 1, `rec_bank_i` = b) makes queries of bank b return 0 from the next cycle on.
- R4: A record of bank b has no effect on the expedite result for any other bank.
- R5: When a query and a record name the same bank in the same cycle, the query returns the result for the state before that record.
- R6: Time is split into halves of H = max(1, floor(L/2)) cycles, where L is `win_len_i`. The first half begins with the first clock cycle after reset is released. A record made during half n keeps its bank non-idle up to the end of half n+1. The bank is idle again in the first cycle of half n+2, provided no later record names it.
- R7: The window length is taken from `win_len_i`, which is held stable between resets. The R6 timing holds for L = 100, 200 and 400.
- R8: Each per-bank count saturates at 2^CNT_W-1 (15 by default). Sixteen records of one bank inside one half still leave it non-idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| win_len_i | input | WIN_W | Window length L in cycles |
| rec_vld_i | input | 1 | A request toward `rec_bank_i` passes the router this cycle |
| rec_bank_i | input | $clog2(NUM_BANKS) | Bank index of the observed request |
| qry_vld_i | input | 1 | Query strobe |
| qry_bank_i | input | $clog2(NUM_BANKS) | Bank index being queried |
| qry_expedite_o | output | 1 | Queried bank is idle in the window (combinational) |

## Verification
A record and a query can fall in the same cycle. When both name the same bank, the query must return the pre-record answer. The bench provokes this on a freshly reset bank, where the expected flag is 1, and then queries that bank again on the next cycle, where the expected flag is 0. A half-window rollover can also coincide with a record. The bench places records on the last cycle of a half and checks the bank's state on the cycles just before and just after the window end computed from R6.

// File: rtl/bhit_pkg.sv
package bhit_pkg;

   // saturating increment on a CNT_W-bit count
   function automatic logic [7:0] sat_inc(input logic [7:0] val, input logic [7:0] max);
      return (val >= max) ? max : val + 8'd1;
   endfunction

endpackage

// File: rtl/bhit_phase.sv
module bhit_phase #(
   parameter int WIN_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIN_W-1:0] win_len_i,
   output logic             roll_o,
   output logic             sel_o
);

   logic [WIN_W-1:0] half_len;
   logic [WIN_W-1:0] ph_cnt;

   always_comb begin
      half_len = win_len_i >> 1;
      if (half_len == '0) half_len = {{(WIN_W-1){1'b0}}, 1'b1};
   end

   assign roll_o = (ph_cnt >= half_len - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_cnt <= '0;
         sel_o  <= 1'b0;
      end else if (roll_o) begin
         ph_cnt <= '0;
         sel_o  <= ~sel_o;
      end else begin
         ph_cnt <= ph_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/bhit_slot.sv
module bhit_slot #(
   parameter int CNT_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc_i,
   input  logic sel_i,
   input  logic roll_i,
   output logic idle_o
);
   import bhit_pkg::*;

   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt0, cnt1;
   logic [7:0]       nxt0, nxt1;

   assign nxt0 = sat_inc(8'(cnt0), 8'(CMAX));
   assign nxt1 = sat_inc(8'(cnt1), 8'(CMAX));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt0 <= '0;
         cnt1 <= '0;
      end else begin
         // inactive set is cleared as it becomes active
         if (roll_i && sel_i)  cnt0 <= '0;
         if (roll_i && !sel_i) cnt1 <= '0;
         if (inc_i && !sel_i)  cnt0 <= nxt0[CNT_W-1:0];
         if (inc_i && sel_i)   cnt1 <= nxt1[CNT_W-1:0];
      end
   end

   assign idle_o = (cnt0 == '0) && (cnt1 == '0);

endmodule

// File: rtl/bank_idle_tracker.sv
module bank_idle_tracker #(
   parameter int NUM_BANKS = 64,
   parameter int CNT_W     = 4,
   parameter int WIN_W     = 10,
   localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WIN_W-1:0]  win_len_i,
   input  logic              rec_vld_i,
   input  logic [BANK_W-1:0] rec_bank_i,
   input  logic              qry_vld_i,
   input  logic [BANK_W-1:0] qry_bank_i,
   output logic              qry_expedite_o
);

   localparam bit POW2 = ((1 << BANK_W) == NUM_BANKS);

   if (NUM_BANKS < 2) begin : g_chk_banks
      $error("NUM_BANKS must be at least 2");
   end
   if (CNT_W < 1 || CNT_W > 8) begin : g_chk_cnt
      $error("CNT_W must be in 1..8");
   end
   if (WIN_W < 2) begin : g_chk_win
      $error("WIN_W must be at least 2");
   end

   logic                 roll, sel;
   logic [NUM_BANKS-1:0] idle_vec;

   bhit_phase #(.WIN_W(WIN_W)) phase_i (
      .clk(clk), .rst_n(rst_n), .win_len_i(win_len_i),
      .roll_o(roll), .sel_o(sel)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_slot
      logic hit;
      assign hit = rec_vld_i && (rec_bank_i == BANK_W'(b));
      bhit_slot #(.CNT_W(CNT_W)) slot_i (
         .clk(clk), .rst_n(rst_n), .inc_i(hit),
         .sel_i(sel), .roll_i(roll), .idle_o(idle_vec[b])
      );
   end

   if (POW2) begin : g_sel_pow2
      assign qry_expedite_o = qry_vld_i && idle_vec[qry_bank_i];
   end else begin : g_sel_guard
      logic in_range;
      assign in_range       = (32'(qry_bank_i) < NUM_BANKS);
      assign qry_expedite_o = qry_vld_i && in_range && idle_vec[qry_bank_i];
   end

endmodule

// File: rtl/bank_idle_tracker_chk.sv
module bank_idle_tracker_chk #(
   parameter int NUM_BANKS = 64,
   parameter int BANK_W    = 6
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 rec_vld_i,
   input logic [BANK_W-1:0]    rec_bank_i,
   input logic                 qry_vld_i,
   input logic                 qry_expedite_o,
   input logic                 roll,
   input logic [NUM_BANKS-1:0] idle_vec
);

   logic       first_cyc;
   logic [1:0] quiet;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         first_cyc <= 1'b1;
         quiet     <= 2'd2;
      end else begin
         first_cyc <= 1'b0;
         if (rec_vld_i)             quiet <= 2'd0;
         else if (roll && quiet != 2'd2) quiet <= quiet + 2'd1;
      end
   end

   p_all_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      first_cyc |-> (&idle_vec));

   p_no_flag_idle_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !qry_vld_i |-> !qry_expedite_o);

   p_rec_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_vld_i && 32'(rec_bank_i) < NUM_BANKS) |=> !idle_vec[$past(rec_bank_i)]);

   p_busy_only_by_rec_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!rec_vld_i && !first_cyc) |=> ($countones(idle_vec) >= $past($countones(idle_vec))));

   p_expire_two_halves_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet == 2'd2) |-> (&idle_vec));

endmodule

bind bank_idle_tracker bank_idle_tracker_chk #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .rec_vld_i(rec_vld_i), .rec_bank_i(rec_bank_i),
   .qry_vld_i(qry_vld_i), .qry_expedite_o(qry_expedite_o),
   .roll(roll), .idle_vec(idle_vec)
);

// File: tb/bank_idle_tracker_tb_top.sv
module bank_idle_tracker_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NB = 64;
   localparam int BW = 6;
   localparam int WW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [WW-1:0] win_len = 10'd8;
   logic          rec_vld = 1'b0;
   logic [BW-1:0] rec_bank = '0;
   logic          qry_vld = 1'b0;
   logic [BW-1:0] qry_bank = '0;
   logic          qry_exp;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bank_idle_tracker #(.NUM_BANKS(NB), .CNT_W(4), .WIN_W(WW)) dut_i (
      .clk(clk), .rst_n(rst_n), .win_len_i(win_len),
      .rec_vld_i(rec_vld), .rec_bank_i(rec_bank),
      .qry_vld_i(qry_vld), .qry_bank_i(qry_bank),
      .qry_expedite_o(qry_exp)
   );

   // {rec_vld, rec_bank, qry_vld, qry_bank, expected, requirement number}
   // run with L=8 (H=4), row index equals cycle since reset
   localparam logic [18:0] VEC [13] = '{
      {1'b1, 6'd5, 1'b1, 6'd5,  1'b1, 4'd5},  // R5 same-cycle, pre-record state
      {1'b0, 6'd0, 1'b1, 6'd5,  1'b0, 4'd3},  // R3 busy next cycle
      {1'b0, 6'd0, 1'b1, 6'd6,  1'b1, 4'd4},  // R4 neighbour untouched
      {1'b0, 6'd0, 1'b0, 6'd6,  1'b0, 4'd2},  // R2 no strobe
      {1'b1, 6'd9, 1'b1, 6'd5,  1'b0, 4'd6},  // R6 second half still busy
      {1'b0, 6'd0, 1'b1, 6'd9,  1'b0, 4'd3},
      {1'b0, 6'd0, 1'b1, 6'd5,  1'b0, 4'd6},
      {1'b0, 6'd0, 1'b1, 6'd5,  1'b0, 4'd6},  // last cycle of half 1
      {1'b0, 6'd0, 1'b1, 6'd5,  1'b1, 4'd6},  // expired at half 2
      {1'b0, 6'd0, 1'b1, 6'd9,  1'b0, 4'd6},
      {1'b0, 6'd0, 1'b1, 6'd0,  1'b1, 4'd4},
      {1'b0, 6'd0, 1'b1, 6'd9,  1'b0, 4'd6},
      {1'b0, 6'd0, 1'b1, 6'd9,  1'b1, 4'd6}   // R6 expiry of half-1 record
   };

   task automatic do_reset(input logic [WW-1:0] len);
      @(negedge clk);
      rst_n = 1'b0; rec_vld = 1'b0; qry_vld = 1'b0; win_len = len;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cyc = 0;
   endtask

   // drive one cycle at the falling edge, optionally check, advance
   task automatic step(input logic rv, input logic [BW-1:0] rb,
                       input logic qv, input logic [BW-1:0] qb,
                       input bit chk, input logic exp, input string req);
      rec_vld = rv; rec_bank = rb; qry_vld = qv; qry_bank = qb;
      #1;
      if (chk) begin
         total++;
         if (qry_exp !== exp) begin
            bad++;
            $display("FAIL %s cyc=%0d bank=%0d actual=%b expected=%b", req, cyc, qb, qry_exp, exp);
         end
      end
      @(posedge clk);
      @(negedge clk);
      cyc++;
   endtask

   task automatic run_to(input int target);
      while (cyc < target) step(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "");
   endtask

   initial begin
      // vector walk, L = 8
      do_reset(10'd8);
      for (int i = 0; i < 13; i++) begin
         step(VEC[i][18], VEC[i][17:12], VEC[i][11], VEC[i][10:5], 1'b1, VEC[i][4],
              $sformatf("R%0d", VEC[i][3:0]));
      end

      // R1: reset state with default window 200
      do_reset(10'd200);
      step(1'b0, '0, 1'b1, 6'd0,  1'b1, 1'b1, "R1");
      step(1'b0, '0, 1'b1, 6'd63, 1'b1, 1'b1, "R1");
      step(1'b1, 6'd7, 1'b1, 6'd31, 1'b1, 1'b1, "R1");
      // R6 with L=200: record on last cycle of half 0
      run_to(99);
      step(1'b1, 6'd63, 1'b1, 6'd7, 1'b1, 1'b0, "R3");
      step(1'b0, '0, 1'b1, 6'd63, 1'b1, 1'b0, "R6");
      run_to(199);
      step(1'b0, '0, 1'b1, 6'd63, 1'b1, 1'b0, "R7");
      step(1'b0, '0, 1'b1, 6'd63, 1'b1, 1'b1, "R7");

      // R1: mid-run reset clears history
      step(1'b1, 6'd12, 1'b0, '0, 1'b0, 1'b0, "");
      step(1'b0, '0, 1'b1, 6'd12, 1'b1, 1'b0, "R3");
      do_reset(10'd100);
      step(1'b0, '0, 1'b1, 6'd12, 1'b1, 1'b1, "R1");

      // R7 with L=100 (H=50)
      run_to(10);
      step(1'b1, 6'd40, 1'b0, '0, 1'b0, 1'b0, "");
      run_to(60);
      step(1'b1, 6'd41, 1'b0, '0, 1'b0, 1'b0, "");
      run_to(99);
      step(1'b0, '0, 1'b1, 6'd40, 1'b1, 1'b0, "R7");
      step(1'b0, '0, 1'b1, 6'd40, 1'b1, 1'b1, "R7");
      run_to(149);
      step(1'b0, '0, 1'b1, 6'd41, 1'b1, 1'b0, "R7");
      step(1'b0, '0, 1'b1, 6'd41, 1'b1, 1'b1, "R7");

      // R8 saturation and R7 with L=400 (H=200)
      do_reset(10'd400);
      for (int k = 0; k < 16; k++) step(1'b1, 6'd3, 1'b0, '0, 1'b0, 1'b0, "");
      step(1'b0, '0, 1'b1, 6'd3, 1'b1, 1'b0, "R8");
      run_to(399);
      step(1'b0, '0, 1'b1, 6'd3, 1'b1, 1'b0, "R7");
      step(1'b0, '0, 1'b1, 6'd3, 1'b1, 1'b1, "R7");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule